// File: doc/BRIEF.md
# Nibble-Wide Multiplexed Bus Slave Interface

This block is the processor-facing front end of a small peripheral that talks over a 4-bit bidirectional data bus. The bus has an address strobe for processors that multiplex address and data, a main chip select (active low), a power chip select (active high), and active-low read and write strobes. Each access targets one of 16 nibble registers. The block samples every bus pin into the core clock domain through a synchronizer. It then decodes the bus mode and either drives the read nibble (a data value plus an output enable, in place of a real tri-state) or hands a completed write to the register file as a one-cycle strobe.

The power chip select also acts as a standby switch. While it is low the block reports back-up mode, keeps the bus released and ignores the strobes. The block also owns a single control bit, the prescaler-clear request, which back-up mode forces to zero. While the core counter reports busy, writes to the counter registers are dropped. The three control registers at the top of the map stay writable at all times.

Top module: `nbus_slave`

## Requirements
- R1: With cs_pwr=1, cs_n=0, rd_n=0 and wr_n=1, data_oe goes to 1 and data_out carries reg_rdata for the selected address. Both are due at the third rising clock edge after the inputs settle, and data_oe returns to 0 three edges after rd_n rises.
- R2: reg_rd is a one-cycle pulse. It rises in the same cycle that data_oe first goes to 1 in a read, and it is 0 on the following cycle.
- R3: A write with cs_pwr=1, cs_n=0, rd_n=1 and wr_n=0 commits when wr_n rises. wr_en is 1 for exactly one cycle, at the third edge after the rise, with wr_addr and wr_data equal to the address and nibble held during the strobe.
- R4: When rd_n and wr_n are both 0 with the chip selected, data_oe stays 0 and no wr_en pulse follows when the strobes are released.
- R5: When cs_pwr=0, backup is 1 (due three edges later), data_oe stays 0 and no write is committed, whatever the other pins do. backup is 0 while cs_pwr=1.
- R6: With cs_pwr=1 and cs_n=1, a read strobe does not drive the bus or pulse reg_rd, and a write strobe commits nothing.
- R7: While ale=1 the address pins select the register directly. While ale=0 the address captured during the last ale-high phase stays selected, and changes on the address pins are ignored.
- R8: While cnt_busy=1, a write to addresses 0x0 to 0xC produces no wr_en. A write to 0xD, 0xE or 0xF commits whatever cnt_busy is.
- R9: rst_bit takes bit 0 of the nibble written to address 0xF. It is forced to 0 in back-up mode, three edges after cs_pwr falls.
- R10: After reset, data_oe, reg_rd, wr_en and rst_bit are 0 and backup is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address latch enable; tie high for a non-multiplexed bus |
| cs_pwr | input | 1 | Power chip select, active high; low selects back-up mode |
| cs_n | input | 1 | Main chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| data_in | input | 4 | Data nibble from the bus |
| data_out | output | 4 | Data nibble toward the bus |
| data_oe | output | 1 | Bus drive enable for data_out |
| reg_addr | output | 4 | Address currently selected for reading |
| reg_rdata | input | 4 | Register file read data for reg_addr |
| reg_rd | output | 1 | One-cycle pulse at the start of a read |
| wr_en | output | 1 | One-cycle write commit strobe |
| wr_addr | output | 4 | Address of the committed write |
| wr_data | output | 4 | Data of the committed write |
| cnt_busy | input | 1 | Core counter is mid-update |
| rst_bit | output | 1 | Prescaler-clear request bit |
| backup | output | 1 | Back-up mode indicator |

## Verification
Every pin change passes through two synchroniser flops and one output register. So data_oe, data_out, reg_rd, backup and rst_bit are due at the third rising edge after the bench changes a pin on a falling edge. A write's wr_en is due at the third edge after wr_n rises, and its absence is checked at the fourth. The driver tasks record, at the moment of each stimulus, the cycle at which every expected value is due. The monitor samples only on falling edges and compares each item in exactly the cycle recorded, so one-cycle pulses are caught and neither a late nor a stray strobe goes unnoticed.

// File: rtl/nbus_pkg.sv
// Shared types for the nibble bus slave.
// Assumes: bus control pins are bundled in a fixed order by the top module.
package nbus_pkg;

    // Decoded state of the bus pins after synchronisation.
    typedef enum logic [2:0] {
        BM_IDLE,
        BM_READ,
        BM_WRITE,
        BM_CLASH,
        BM_BACKUP
    } bus_mode_e;

    // Synchronised control pins.
    typedef struct packed {
        logic ale;
        logic cs_pwr;
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } bus_ctl_t;

    localparam int unsigned CTL_W = 5;

endpackage

// File: rtl/nbus_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous bus pins.
// Assumes: each bit is used independently or is stable for several cycles
// around the moment it is used together with other bits.
module nbus_sync #(
    parameter int unsigned         W      = 8,
    parameter int unsigned         STAGES = 2,
    parameter logic [W-1:0]        INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= INIT;
                    else        stg[gi] <= d;
                end
            end else begin : g_next
                // Later stages settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= INIT;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/nbus_decode.sv
// Decodes the synchronised bus pins into a bus mode and selects the
// register address, either straight through (ale high) or from the latch.
// Assumes: inputs come from nbus_sync; back-up mode outranks all others.
module nbus_decode
    import nbus_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_ctl_t      ctl,
    input  logic [AW-1:0] addr_s,
    output bus_mode_e     mode,
    output logic [AW-1:0] sel_addr
);

    logic [AW-1:0] addr_lat;

    // Address latch follows the pins while ale is high and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_lat <= '0;
        else if (ctl.ale) addr_lat <= addr_s;
    end

    // Transparent path while ale is high, latched value once it falls.
    assign sel_addr = ctl.ale ? addr_s : addr_lat;

    // Mode decode: back-up first, then chip select, then the strobe pair.
    always_comb begin
        if (!ctl.cs_pwr) begin
            mode = BM_BACKUP;
        end else if (ctl.cs_n) begin
            mode = BM_IDLE;
        end else begin
            unique case ({ctl.rd_n, ctl.wr_n})
                2'b01:   mode = BM_READ;
                2'b10:   mode = BM_WRITE;
                2'b00:   mode = BM_CLASH;
                default: mode = BM_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nbus_access.sv
// Turns the bus mode into register-file actions: read drive, read pulse,
// write commit on the strobe's trailing edge, busy guard and the
// prescaler-clear bit.
// Assumes: write address and data are stable while the strobe is low.
module nbus_access
    import nbus_pkg::*;
#(
    parameter int unsigned    AW        = 4,
    parameter int unsigned    DW        = 4,
    parameter logic [AW-1:0]  CTRL_BASE = 4'hD,
    parameter logic [AW-1:0]  RST_ADDR  = 4'hF,
    parameter int unsigned    RST_POS   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_mode_e     mode,
    input  logic          wr_n_s,
    input  logic [AW-1:0] sel_addr,
    input  logic [DW-1:0] data_s,
    input  logic [DW-1:0] reg_rdata,
    input  logic          cnt_busy,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic          reg_rd,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rst_bit,
    output logic          backup
);

    logic          prev_read;
    logic          prev_write;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          commit;
    logic          commit_ok;

    // Write ends when the strobe rises after a write cycle, outside back-up.
    assign commit    = prev_write && wr_n_s && (mode != BM_BACKUP);
    assign commit_ok = commit && ((hold_addr >= CTRL_BASE) || !cnt_busy);

    // Remember the previous mode for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_read  <= 1'b0;
            prev_write <= 1'b0;
        end else begin
            prev_read  <= (mode == BM_READ);
            prev_write <= (mode == BM_WRITE);
        end
    end

    // Capture write address and data while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr <= '0;
            hold_data <= '0;
        end else if (mode == BM_WRITE) begin
            hold_addr <= sel_addr;
            hold_data <= data_s;
        end
    end

    // Read drive, read pulse and back-up flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_oe  <= 1'b0;
            data_out <= '0;
            reg_rd   <= 1'b0;
            backup   <= 1'b1;
        end else begin
            data_oe  <= (mode == BM_READ);
            data_out <= (mode == BM_READ) ? reg_rdata : '0;
            reg_rd   <= (mode == BM_READ) && !prev_read;
            backup   <= (mode == BM_BACKUP);
        end
    end

    // Write commit strobe toward the register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= commit_ok;
            if (commit_ok) begin
                wr_addr <= hold_addr;
                wr_data <= hold_data;
            end
        end
    end

    // Prescaler-clear bit: set by a write, cleared by back-up mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_bit <= 1'b0;
        end else if (mode == BM_BACKUP) begin
            rst_bit <= 1'b0;
        end else if (commit_ok && (hold_addr == RST_ADDR)) begin
            rst_bit <= hold_data[RST_POS];
        end
    end

endmodule

// File: rtl/nbus_slave.sv
// Top of the nibble bus slave: synchronises the bus pins, decodes the mode
// and drives register-file strobes and the data nibble.
// Assumes: the register file answers reg_rdata combinationally from reg_addr.
module nbus_slave
    import nbus_pkg::*;
#(
    parameter int unsigned   AW          = 4,
    parameter int unsigned   DW          = 4,
    parameter int unsigned   SYNC_STAGES = 2,
    parameter logic [AW-1:0] CTRL_BASE   = 4'hD,
    parameter logic [AW-1:0] RST_ADDR    = 4'hF,
    parameter int unsigned   RST_POS     = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic          cs_pwr,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    output logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_rdata,
    output logic          reg_rd,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    input  logic          cnt_busy,
    output logic          rst_bit,
    output logic          backup
);

    localparam int unsigned   SW        = CTL_W + AW + DW;
    localparam logic [CTL_W-1:0] CTL_INIT = 5'b00111;
    localparam logic [SW-1:0] SYNC_INIT = {CTL_INIT, {(AW + DW){1'b0}}};

    logic [SW-1:0] pins_raw;
    logic [SW-1:0] pins_s;
    bus_ctl_t      ctl_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    bus_mode_e     mode;
    logic [AW-1:0] sel_addr;

    assign pins_raw = {ale, cs_pwr, cs_n, rd_n, wr_n, addr, data_in};
    assign ctl_s    = pins_s[SW-1 -: CTL_W];
    assign addr_s   = pins_s[AW+DW-1 -: AW];
    assign data_s   = pins_s[DW-1:0];
    assign reg_addr = sel_addr;

    nbus_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .INIT   (SYNC_INIT)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    nbus_decode #(
        .AW (AW)
    ) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl_s),
        .addr_s   (addr_s),
        .mode     (mode),
        .sel_addr (sel_addr)
    );

    nbus_access #(
        .AW        (AW),
        .DW        (DW),
        .CTRL_BASE (CTRL_BASE),
        .RST_ADDR  (RST_ADDR),
        .RST_POS   (RST_POS)
    ) i_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .wr_n_s    (ctl_s.wr_n),
        .sel_addr  (sel_addr),
        .data_s    (data_s),
        .reg_rdata (reg_rdata),
        .cnt_busy  (cnt_busy),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .reg_rd    (reg_rd),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rst_bit   (rst_bit),
        .backup    (backup)
    );

endmodule

// File: rtl/nbus_slave_chk.sv
// Property checker for nbus_slave, attached through bind.
// Assumes: observed only through the top module's ports.
module nbus_slave_chk #(
    parameter int unsigned   AW        = 4,
    parameter logic [AW-1:0] CTRL_BASE = 4'hD
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_oe,
    input logic          reg_rd,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          cnt_busy,
    input logic          rst_bit,
    input logic          backup
);

    AST_READ_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);                                              // R2
    AST_READ_PULSE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> data_oe);                                              // R2
    AST_WRITE_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);                                                // R3
    AST_BACKUP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !backup);                                             // R5
    AST_BUSY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < CTRL_BASE)) |-> !$past(cnt_busy));           // R8
    AST_BACKUP_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        backup |-> !rst_bit);                                             // R9

endmodule

bind nbus_slave nbus_slave_chk #(
    .AW        (AW),
    .CTRL_BASE (CTRL_BASE)
) i_nbus_slave_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_oe  (data_oe),
    .reg_rd   (reg_rd),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cnt_busy (cnt_busy),
    .rst_bit  (rst_bit),
    .backup   (backup)
);

// File: tb/test_nbus_slave.sv
// Scoreboard bench for nbus_slave: driver tasks queue expected items with
// the cycle they are due; a falling-edge monitor compares them.
module test_nbus_slave;

    localparam int K_OE = 0;
    localparam int K_RD = 1;
    localparam int K_WR = 2;
    localparam int K_BK = 3;
    localparam int K_RB = 4;

    typedef struct {
        int          due;
        int          kind;
        logic [11:0] exp;
        string       req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ale = 1'b1;
    logic       cs_pwr = 1'b1;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [3:0] addr = 4'h0;
    logic [3:0] data_in = 4'h0;
    logic [3:0] data_out;
    logic       data_oe;
    logic [3:0] reg_addr;
    logic [3:0] reg_rdata;
    logic       reg_rd;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [3:0] wr_data;
    logic       cnt_busy = 1'b0;
    logic       rst_bit;
    logic       backup;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Register file model: each register holds its address xor 0xA.
    assign reg_rdata = reg_addr ^ 4'hA;

    nbus_slave i_nbus_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .cs_pwr    (cs_pwr),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .data_in   (data_in),
        .data_out  (data_out),
        .data_oe   (data_oe),
        .reg_addr  (reg_addr),
        .reg_rdata (reg_rdata),
        .reg_rd    (reg_rd),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_busy  (cnt_busy),
        .rst_bit   (rst_bit),
        .backup    (backup)
    );

    function automatic void expect_at(int delta, int kind, logic [11:0] exp, string req);
        item_t it;
        it.due  = cyc + delta;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endfunction

    function automatic void check(string req, logic [11:0] act, logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endfunction

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                case (sb[i].kind)
                    K_OE: check(sb[i].req, {7'd0, data_oe, data_out}, sb[i].exp);
                    K_RD: check(sb[i].req, {11'd0, reg_rd}, sb[i].exp);
                    K_WR: begin
                        if (sb[i].exp[8])
                            check(sb[i].req, {3'd0, wr_en, wr_addr, wr_data}, sb[i].exp);
                        else
                            check(sb[i].req, {3'd0, wr_en, 8'd0}, sb[i].exp);
                    end
                    K_BK: check(sb[i].req, {11'd0, backup}, sb[i].exp);
                    default: check(sb[i].req, {11'd0, rst_bit}, sb[i].exp);
                endcase
                sb.delete(i);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Read access; drives=1 when the bus should be driven.
    task automatic bus_read(logic [3:0] a, logic [3:0] exp_sel, bit drives, string req);
        @(negedge clk);
        addr = a;
        rd_n = 1'b0;
        if (drives) begin
            expect_at(3, K_OE, {7'd0, 1'b1, exp_sel ^ 4'hA}, req);
            expect_at(3, K_RD, 12'd1, req);
            expect_at(4, K_RD, 12'd0, req);
        end else begin
            expect_at(3, K_OE, 12'd0, req);
            expect_at(3, K_RD, 12'd0, req);
        end
        idle(5);
        rd_n = 1'b1;
        expect_at(3, K_OE, 12'd0, req);
        idle(5);
    endtask

    // Write access; ok=1 when a commit is expected at the strobe's rise.
    task automatic bus_write(logic [3:0] a, logic [3:0] d, bit ok, string req);
        @(negedge clk);
        addr    = a;
        data_in = d;
        wr_n    = 1'b0;
        idle(4);
        wr_n = 1'b1;
        if (ok) expect_at(3, K_WR, {3'd0, 1'b1, a, d}, req);
        else    expect_at(3, K_WR, 12'd0, req);
        expect_at(4, K_WR, 12'd0, req);
        idle(6);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check("R10", {7'd0, data_oe, reg_rd, wr_en, rst_bit, backup}, 12'h001);
        rst_n = 1'b1;
        expect_at(3, K_BK, 12'd0, "R5");
        idle(5);

        // R6: not selected
        bus_read(4'h2, 4'h2, 1'b0, "R6");
        bus_write(4'h3, 4'h6, 1'b0, "R6");

        cs_n = 1'b0;
        idle(3);
        // R1/R2: reads with the address passing straight through
        bus_read(4'h2, 4'h2, 1'b1, "R1");
        bus_read(4'hB, 4'hB, 1'b1, "R2");
        bus_read(4'h7, 4'h7, 1'b1, "R1");

        // R3: writes
        bus_write(4'h5, 4'h9, 1'b1, "R3");
        bus_write(4'hC, 4'h3, 1'b1, "R3");

        // R4: both strobes low
        @(negedge clk);
        addr = 4'h4; data_in = 4'hE;
        rd_n = 1'b0; wr_n = 1'b0;
        expect_at(3, K_OE, 12'd0, "R4");
        expect_at(3, K_RD, 12'd0, "R4");
        idle(4);
        rd_n = 1'b1; wr_n = 1'b1;
        expect_at(3, K_WR, 12'd0, "R4");
        expect_at(4, K_WR, 12'd0, "R4");
        idle(6);

        // R8: busy guard
        cnt_busy = 1'b1;
        bus_write(4'h2, 4'h1, 1'b0, "R8");
        bus_write(4'hC, 4'h1, 1'b0, "R8");
        bus_write(4'hE, 4'h5, 1'b1, "R8");
        cnt_busy = 1'b0;

        // R7: latch address 3, then move the pins to 9 with ale low
        @(negedge clk);
        addr = 4'h3; ale = 1'b1;
        idle(3);
        ale = 1'b0; addr = 4'h9;
        idle(3);
        bus_read(4'h9, 4'h3, 1'b1, "R7");
        ale = 1'b1;
        idle(3);

        // R9: set the prescaler-clear bit
        bus_write(4'hF, 4'h1, 1'b1, "R9");
        expect_at(0, K_RB, 12'd1, "R9");
        idle(2);

        // R5/R9: drop into back-up mode with the chip selected
        @(negedge clk);
        cs_pwr = 1'b0;
        expect_at(3, K_BK, 12'd1, "R5");
        expect_at(3, K_RB, 12'd0, "R9");
        idle(5);
        bus_read(4'h1, 4'h1, 1'b0, "R5");
        bus_write(4'h1, 4'h7, 1'b0, "R5");
        expect_at(0, K_BK, 12'd1, "R5");

        @(negedge clk);
        cs_pwr = 1'b1;
        expect_at(3, K_BK, 12'd0, "R5");
        idle(5);
        bus_write(4'hD, 4'h8, 1'b1, "R3");
        idle(8);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule